// File: doc/BRIEF.md
# Two-Dimensional Scan Address Sequencer

This block generates a stream of (x, y) coordinates for a two-dimensional data memory, so that a stream-driven datapath array can be fed without any instruction fetch. A start pulse loads a current point from a programmed base point. The point then moves by a signed per-axis step on every address the consumer accepts. The step is added or subtracted according to a direction control. A sweep stops at the first of three events: the point matches a limit point (each axis of the match may be masked as a wildcard), the number of steps reaches a programmed maximum, or an escape input is raised.

Between sweeps, the base point and the limit point each slide by their own signed step vectors. The next sweep then restarts from the moved base. This produces nested scans such as row-by-row walks and sliding windows. After a programmed number of slides the sequencer returns to idle. Coordinates are 8-bit unsigned values and wrap modulo 256. Step components are 8-bit two's complement values.

Top module: `addr_gen_2d`

## Requirements
- R1: After reset the sequencer is idle: busy, addrValid and endExec are all 0.
- R2: A start pulse while idle loads base and limit from the inputs. In the next cycle busy is 1 and the address equals (baseX, baseY). A start pulse while busy is ignored, and so is a change of baseX/baseY while busy.
- R3: Each accepted address (addrValid and ready both 1) that does not end the sweep moves the address in the next cycle. With dirNeg=0 each axis adds its step; with dirNeg=1 each axis subtracts its step. Arithmetic is modulo 256 and steps are two's complement.
- R4: While addrValid is 1 and ready is 0, the address and addrValid hold unchanged into the next cycle.
- R5: The last address of a sweep is one that equals the current limit on every axis not masked. limitMask bit 0 masks x and bit 1 masks y; a masked axis always counts as matching.
- R6: A sweep also ends once maxSteps steps have been taken, so it emits at most maxSteps+1 addresses.
- R7: While escape is 1 and busy is 1, addrValid is 0, and the current sweep ends in that cycle without emitting the held address.
- R8: endExec is 1 for exactly the one cycle that follows each sweep-ending event, so one operation yields numSlides+1 pulses.
- R9: After a sweep ends with fewer than numSlides slides done, base moves by (baseStepX, baseStepY) and limit moves by (limitStepX, limitStepY). The next sweep starts at the new base in the cycle after the end. After the final sweep, busy is 0 in the cycle after the end.
- R10: Programmed one diagonal per operation, alternating the direction control, the sequencer emits the 64 positions of an 8x8 zigzag block scan in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (used only while idle) |
| baseX | input | 8 | Starting base x |
| baseY | input | 8 | Starting base y |
| limitX | input | 8 | Starting limit x |
| limitY | input | 8 | Starting limit y |
| stepX | input | 8 | Inner step x, two's complement |
| stepY | input | 8 | Inner step y, two's complement |
| dirNeg | input | 1 | 1: subtract step, 0: add step |
| maxSteps | input | 8 | Maximum steps per sweep |
| limitMask | input | 2 | Bit 0 masks x, bit 1 masks y in the limit match |
| baseStepX | input | 8 | Base slide x, two's complement |
| baseStepY | input | 8 | Base slide y, two's complement |
| limitStepX | input | 8 | Limit slide x, two's complement |
| limitStepY | input | 8 | Limit slide y, two's complement |
| numSlides | input | 8 | Number of slides (sweeps minus one) |
| escape | input | 1 | Abort current sweep |
| ready | input | 1 | Consumer accepts the address |
| addrX | output | 8 | Current address x |
| addrY | output | 8 | Current address y |
| addrValid | output | 1 | Address offered |
| endExec | output | 1 | One-cycle pulse after a sweep ends |
| busy | output | 1 | Operation in progress |

## Verification
The bound checker watches, on every cycle, the properties that depend only on neighbouring cycles. These are: quiet outputs while idle, the base load after start, the address holding during a stall, escape blanking the strobe and producing an end pulse, and end pulses never following an idle cycle. The bench scenarios cover the properties that span whole sweeps. These include the exact address order under each end condition, wraparound, masked limit matches, base and limit slides across several sweeps, and ignored mid-run starts. They also include constrained-random configurations with random back-pressure and the full zigzag block order.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef struct packed {
    logic load;   // capture base/limit from inputs, point = base
    logic step;   // advance point by inner step
    logic slide;  // move base and limit, point = new base
  } agenCtrl_t;

  typedef enum logic {ST_IDLE, ST_RUN} agenState_t;
endpackage

// File: rtl/agen_datapath.sv
module agen_datapath
  import agen_pkg::*;
#(
  parameter int COORD_W = 8,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  agenCtrl_t          ctrl,
  input  logic [COORD_W-1:0] baseX,
  input  logic [COORD_W-1:0] baseY,
  input  logic [COORD_W-1:0] limitX,
  input  logic [COORD_W-1:0] limitY,
  input  logic [COORD_W-1:0] stepX,
  input  logic [COORD_W-1:0] stepY,
  input  logic               dirNeg,
  input  logic [COORD_W-1:0] baseStepX,
  input  logic [COORD_W-1:0] baseStepY,
  input  logic [COORD_W-1:0] limitStepX,
  input  logic [COORD_W-1:0] limitStepY,
  input  logic [CNT_W-1:0]   maxSteps,
  input  logic [1:0]         limitMask,
  output logic [COORD_W-1:0] addrX,
  output logic [COORD_W-1:0] addrY,
  output logic               lastAddr
);
  localparam int AXES = 2;

  logic [AXES-1:0][COORD_W-1:0] baseIn, limitIn, stepIn, bStepIn, lStepIn, pointQ;
  logic [AXES-1:0]              axisHit;
  logic [CNT_W-1:0]             stepCnt;

  assign baseIn  = {baseY, baseX};
  assign limitIn = {limitY, limitX};
  assign stepIn  = {stepY, stepX};
  assign bStepIn = {baseStepY, baseStepX};
  assign lStepIn = {limitStepY, limitStepX};

  for (genvar g = 0; g < AXES; g++) begin : gAxis
    logic [COORD_W-1:0] baseQ, limitQ, nextBase;
    assign nextBase = baseQ + bStepIn[g];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ     <= '0;
        limitQ    <= '0;
        pointQ[g] <= '0;
      end else if (ctrl.load) begin
        baseQ     <= baseIn[g];
        limitQ    <= limitIn[g];
        pointQ[g] <= baseIn[g];
      end else if (ctrl.slide) begin
        baseQ     <= nextBase;
        limitQ    <= limitQ + lStepIn[g];
        pointQ[g] <= nextBase;
      end else if (ctrl.step) begin
        pointQ[g] <= dirNeg ? pointQ[g] - stepIn[g] : pointQ[g] + stepIn[g];
      end
    end

    assign axisHit[g] = limitMask[g] | (pointQ[g] == limitQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      stepCnt <= '0;
    else if (ctrl.load | ctrl.slide) stepCnt <= '0;
    else if (ctrl.step)             stepCnt <= stepCnt + 1'b1;
  end

  assign lastAddr = (&axisHit) | (stepCnt == maxSteps);
  assign addrX    = pointQ[0];
  assign addrY    = pointQ[1];
endmodule

// File: rtl/agen_control.sv
module agen_control
  import agen_pkg::*;
#(
  parameter int SLIDE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               escape,
  input  logic               ready,
  input  logic               lastAddr,
  input  logic [SLIDE_W-1:0] numSlides,
  output agenCtrl_t          ctrl,
  output logic               addrValid,
  output logic               endExec,
  output logic               busy
);
  agenState_t         state;
  logic [SLIDE_W-1:0] slideCnt;
  logic               fire, sweepEnd, moreSlides;

  always_comb begin
    addrValid  = (state == ST_RUN) & ~escape;
    fire       = addrValid & ready;
    sweepEnd   = (state == ST_RUN) & (escape | (fire & lastAddr));
    moreSlides = (slideCnt != numSlides);
    ctrl.load  = (state == ST_IDLE) & start;
    ctrl.step  = fire & ~lastAddr;
    ctrl.slide = sweepEnd & moreSlides;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      slideCnt <= '0;
      endExec  <= 1'b0;
    end else begin
      endExec <= sweepEnd;
      if (ctrl.load) begin
        state    <= ST_RUN;
        slideCnt <= '0;
      end else if (sweepEnd) begin
        if (moreSlides) slideCnt <= slideCnt + 1'b1;
        else            state    <= ST_IDLE;
      end
    end
  end

  assign busy = (state == ST_RUN);
endmodule

// File: rtl/addr_gen_2d.sv
module addr_gen_2d
  import agen_pkg::*;
#(
  parameter int COORD_W = 8,
  parameter int CNT_W   = 8,
  parameter int SLIDE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COORD_W-1:0] baseX,
  input  logic [COORD_W-1:0] baseY,
  input  logic [COORD_W-1:0] limitX,
  input  logic [COORD_W-1:0] limitY,
  input  logic [COORD_W-1:0] stepX,
  input  logic [COORD_W-1:0] stepY,
  input  logic               dirNeg,
  input  logic [CNT_W-1:0]   maxSteps,
  input  logic [1:0]         limitMask,
  input  logic [COORD_W-1:0] baseStepX,
  input  logic [COORD_W-1:0] baseStepY,
  input  logic [COORD_W-1:0] limitStepX,
  input  logic [COORD_W-1:0] limitStepY,
  input  logic [SLIDE_W-1:0] numSlides,
  input  logic               escape,
  input  logic               ready,
  output logic [COORD_W-1:0] addrX,
  output logic [COORD_W-1:0] addrY,
  output logic               addrValid,
  output logic               endExec,
  output logic               busy
);
  agenCtrl_t ctrl;
  logic      lastAddr;

  agen_control #(.SLIDE_W(SLIDE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .escape(escape), .ready(ready),
    .lastAddr(lastAddr), .numSlides(numSlides), .ctrl(ctrl),
    .addrValid(addrValid), .endExec(endExec), .busy(busy)
  );

  agen_datapath #(.COORD_W(COORD_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .baseX(baseX), .baseY(baseY), .limitX(limitX), .limitY(limitY),
    .stepX(stepX), .stepY(stepY), .dirNeg(dirNeg),
    .baseStepX(baseStepX), .baseStepY(baseStepY),
    .limitStepX(limitStepX), .limitStepY(limitStepY),
    .maxSteps(maxSteps), .limitMask(limitMask),
    .addrX(addrX), .addrY(addrY), .lastAddr(lastAddr)
  );
endmodule

// File: rtl/agen_checker.sv
module agen_checker #(
  parameter int COORD_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               escape,
  input logic               ready,
  input logic [COORD_W-1:0] baseX,
  input logic [COORD_W-1:0] baseY,
  input logic [COORD_W-1:0] addrX,
  input logic [COORD_W-1:0] addrY,
  input logic               addrValid,
  input logic               endExec,
  input logic               busy
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !addrValid);

  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && addrX == $past(baseX) && addrY == $past(baseY)));

  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !ready) |=> ($stable(addrX) && $stable(addrY) && busy));

  assert_escape_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && escape) |=> endExec);

  assert_end_after_run_R8: assert property (@(posedge clk) disable iff (!rstN)
    endExec |-> $past(busy));
endmodule

bind addr_gen_2d agen_checker #(.COORD_W(COORD_W)) i_agen_checker (.*);

// File: tb/test_addr_gen_2d.sv
module test_addr_gen_2d;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN, start, escape, ready, dirNeg;
  logic [7:0] baseX, baseY, limitX, limitY, stepX, stepY;
  logic [7:0] baseStepX, baseStepY, limitStepX, limitStepY, maxSteps, numSlides;
  logic [1:0] limitMask;
  logic [7:0] addrX, addrY;
  logic addrValid, endExec, busy;

  int nChecks = 0;
  int nFail   = 0;
  logic [15:0] expQ[$];
  logic [15:0] gotQ[$];
  logic [15:0] zzQ[$];
  int ends;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_gen_2d i_addr_gen_2d (
    .clk(clk), .rstN(rstN), .start(start),
    .baseX(baseX), .baseY(baseY), .limitX(limitX), .limitY(limitY),
    .stepX(stepX), .stepY(stepY), .dirNeg(dirNeg), .maxSteps(maxSteps),
    .limitMask(limitMask), .baseStepX(baseStepX), .baseStepY(baseStepY),
    .limitStepX(limitStepX), .limitStepY(limitStepY), .numSlides(numSlides),
    .escape(escape), .ready(ready), .addrX(addrX), .addrY(addrY),
    .addrValid(addrValid), .endExec(endExec), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "ALL", "watchdog expired", 1, 0);
    summary();
  end

  // Expected sequence from R3/R5/R6/R9 (no escape)
  task automatic buildExpected();
    logic [7:0] bx, by, lx, ly, ax, ay;
    int cnt;
    expQ.delete();
    bx = baseX; by = baseY; lx = limitX; ly = limitY;
    for (int s = 0; s <= int'(numSlides); s++) begin
      ax = bx; ay = by; cnt = 0;
      while (1) begin
        expQ.push_back({ay, ax});
        if (((limitMask[0] || ax == lx) && (limitMask[1] || ay == ly)) ||
            cnt == int'(maxSteps)) break;
        if (dirNeg) begin ax = ax - stepX; ay = ay - stepY; end
        else        begin ax = ax + stepX; ay = ay + stepY; end
        cnt++;
      end
      bx = bx + baseStepX; by = by + baseStepY;
      lx = lx + limitStepX; ly = limitY + 8'(ly - limitY) + limitStepY;
    end
  endtask

  task automatic runOp(input string req, input int stallPct, input bit poke);
    bit done = 0;
    bit holdPending = 0;
    logic [15:0] holdAddr = '0;
    logic [7:0] savedBase;
    buildExpected();
    gotQ.delete();
    ends = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      ready = (int'($urandom % 100) >= stallPct);
      if (poke && cyc == 2) begin
        start = 1'b1; savedBase = baseX; baseX = baseX ^ 8'h55;
      end
      if (poke && cyc == 3) begin
        start = 1'b0; baseX = savedBase;
      end
      #1;
      if (holdPending)  // R4
        check(addrValid && {addrY, addrX} == holdAddr, "R4", "stall hold",
              int'({addrY, addrX}), int'(holdAddr));
      holdPending = addrValid && !ready;
      holdAddr = {addrY, addrX};
      if (addrValid && ready) gotQ.push_back({addrY, addrX});
      if (endExec) ends++;
      if (!busy) begin done = 1; break; end
      @(negedge clk);
    end
    if (poke) begin start = 1'b0; end
    check(done, req, "operation finished", int'(done), 1);
    check(gotQ.size() == expQ.size(), req, "address count", gotQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      check(gotQ[i] == expQ[i], req, $sformatf("address %0d {y,x}", i),
            int'(gotQ[i]), int'(expQ[i]));
    check(ends == int'(numSlides) + 1, "R8", "endExec pulses", ends, int'(numSlides) + 1);
  endtask

  task automatic setCfg(input logic [7:0] bx, by, lx, ly, sx, sy, input logic dn,
                        input logic [7:0] mx, input logic [1:0] mk);
    baseX = bx; baseY = by; limitX = lx; limitY = ly; stepX = sx; stepY = sy;
    dirNeg = dn; maxSteps = mx; limitMask = mk;
    baseStepX = 0; baseStepY = 0; limitStepX = 0; limitStepY = 0; numSlides = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; start = 0; escape = 0; ready = 1;
    setCfg(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !addrValid && !endExec, "R1", "reset quiet",
          int'({busy, addrValid, endExec}), 0);
    @(negedge clk); rstN = 1'b1;

    // R3/R5: row walk, add
    setCfg(2, 3, 6, 3, 1, 0, 0, 255, 0);
    runOp("R3", 0, 0);
    // R3: subtract direction
    setCfg(10, 10, 4, 7, 2, 1, 1, 255, 0);
    runOp("R3", 20, 0);
    // R3: wraparound modulo 256
    setCfg(250, 0, 6, 0, 4, 0, 0, 255, 0);
    runOp("R3", 0, 0);
    // R6: count end, limit unreachable
    setCfg(0, 0, 1, 200, 1, 0, 0, 5, 0);
    runOp("R6", 30, 0);
    // R5: x masked as wildcard
    setCfg(0, 0, 99, 5, 1, 1, 0, 255, 2'b01);
    runOp("R5", 0, 0);
    // R5: y masked as wildcard
    setCfg(0, 0, 4, 99, 1, 1, 0, 255, 2'b10);
    runOp("R5", 10, 0);
    // R9: row-by-row scan via base/limit slides
    setCfg(0, 0, 3, 0, 1, 0, 0, 255, 0);
    baseStepY = 1; limitStepY = 1; numSlides = 3;
    runOp("R9", 25, 0);
    // R9: sliding window in x
    setCfg(0, 5, 2, 5, 1, 0, 0, 255, 0);
    baseStepX = 1; limitStepX = 1; numSlides = 4;
    runOp("R9", 0, 0);
    // R2: start and base change while busy ignored
    setCfg(1, 1, 9, 1, 1, 0, 0, 255, 0);
    runOp("R2", 0, 1);

    // R7: escape mid-sweep, then next sweep from slid base
    setCfg(0, 0, 200, 0, 1, 0, 0, 255, 0);
    baseStepY = 1; numSlides = 1;
    @(negedge clk); start = 1; ready = 1;
    @(negedge clk); start = 0;
    #1;
    check(addrValid && addrX == 0 && addrY == 0, "R2", "loaded base",
          int'({addrY, addrX}), 0);
    repeat (2) @(negedge clk);
    escape = 1; #1;
    check(!addrValid, "R7", "valid blanked by escape", int'(addrValid), 0);
    check(addrX == 2, "R3", "point before escape", int'(addrX), 2);
    @(negedge clk); escape = 0; #1;
    check(endExec && busy, "R8", "pulse after escape", int'({endExec, busy}), 3);
    check(addrValid && addrX == 0 && addrY == 1, "R9", "restart at slid base",
          int'({addrY, addrX}), 16'h0100);
    @(negedge clk); escape = 1; #1;
    check(!addrValid, "R7", "valid blanked second sweep", int'(addrValid), 0);
    @(negedge clk); escape = 0; #1;
    check(endExec && !busy, "R9", "idle after last sweep", int'({endExec, busy}), 2);
    @(negedge clk); #1;
    check(!endExec, "R8", "single-cycle pulse", int'(endExec), 0);

    // Constrained random configurations
    for (int k = 0; k < 12; k++) begin
      setCfg(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
             8'($urandom), 8'($urandom), 1'($urandom), 8'($urandom % 12),
             2'($urandom));
      baseStepX = 8'($urandom); baseStepY = 8'($urandom);
      limitStepX = 8'($urandom); limitStepY = 8'($urandom);
      numSlides = 8'($urandom % 3);
      runOp("R6", 30, 0);
    end

    // R10: zigzag block order, one diagonal per operation
    zzQ.delete();
    for (int d = 0; d < 15; d++) begin
      int n, sx, sy;
      n = (d < 8) ? d + 1 : 15 - d;
      if (d % 2 == 0) begin
        sy = (d < 8) ? d : 7; sx = d - sy;
        setCfg(8'(sx), 8'(sy), 8'(sx + n - 1), 8'(sy - (n - 1)), 8'd1, 8'hFF,
               1'b0, 8'(n - 1), 2'b00);
      end else begin
        sx = (d < 8) ? d : 7; sy = d - sx;
        setCfg(8'(sx), 8'(sy), 8'(sx - (n - 1)), 8'(sy + n - 1), 8'd1, 8'hFF,
               1'b1, 8'(n - 1), 2'b00);
      end
      runOp("R10", 15, 0);
      foreach (gotQ[i]) zzQ.push_back(gotQ[i]);
    end
    begin
      int x = 0, y = 0;
      check(zzQ.size() == 64, "R10", "zigzag length", zzQ.size(), 64);
      for (int i = 0; i < 64 && i < zzQ.size(); i++) begin
        check(zzQ[i] == {8'(y), 8'(x)}, "R10", $sformatf("zigzag position %0d", i),
              int'(zzQ[i]), int'({8'(y), 8'(x)}));
        if ((x + y) % 2 == 0) begin
          if (x == 7) y++; else if (y == 0) x++; else begin x++; y--; end
        end else begin
          if (y == 7) x++; else if (x == 0) y++; else begin x--; y++; end
        end
      end
    end

    summary();
  end
endmodule